// File: doc/BRIEF.md
# Serial Readback Checksum Appender

This block sits on a serial readback stream. Each accepted input bit is forwarded one cycle later, unchanged, and is also folded into a 16-bit CRC built on the polynomial x^16 + x^12 + x^5 + 1. The CRC is fed most significant bit first and starts from zero at the beginning of every pass.

When the input bit flagged as the end of the data is accepted, the block appends a trailer of 11 bits. These are the top eleven bits of the finished CRC, sent most significant first, and the last of them carries the output end flag. Input is refused while the trailer is going out.

The full 16-bit checksum of the most recent pass is held on an output port. A host can also load an 11-bit reference value, and a compare flag reports whether the trailer of the latest pass equals it. A changed checksum means the readback stream changed. Such a comparison is only meaningful when the read data does not depend on the device's changing state.

Top module: `rb_crc_appender`

## Requirements
- R1: Every input bit accepted (in_valid and in_ready high at a clock edge) appears on out_bit with out_valid high exactly one cycle later, with out_last low.
- R2: The checksum uses polynomial 0x1021 (x^16+x^12+x^5+1). It is updated most significant bit first as crc = (crc<<1) ^ ((crc[15]^bit) ? 0x1021 : 0), and starts from 0. One cycle after a pass's end bit is accepted, crc_full equals the CRC of all bits of that pass, the end bit included.
- R3: Directly after the end bit has been forwarded, out_valid stays high for 11 consecutive cycles. These cycles carry crc[15] down to crc[5] of that pass's checksum, in that order.
- R4: out_last is high only during the 11th trailer bit and at no other time.
- R5: in_ready is low for exactly the 11 cycles that follow acceptance of an end bit. Input offered in those cycles is ignored: it produces no output and does not affect any checksum.
- R6: Every pass starts from a zero CRC, so a pass's checksum depends only on its own bits.
- R7: When ref_load is high at an edge, ref_value is stored. match is high exactly when at least one pass has completed and crc_full[15:5] equals the stored reference.
- R8: After reset, out_valid, out_last and match are 0, in_ready is 1, and crc_full is 0.
- R9: During the data phase, a cycle without an accepted input bit produces no output bit in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_bit | input | 1 | Serial readback data bit |
| in_valid | input | 1 | in_bit is offered this cycle |
| in_last | input | 1 | The offered bit is the last of the pass |
| in_ready | output | 1 | The block accepts input this cycle |
| out_bit | output | 1 | Forwarded data bit or trailer bit |
| out_valid | output | 1 | out_bit is meaningful this cycle |
| out_last | output | 1 | Final trailer bit of the pass |
| crc_full | output | 16 | Full checksum of the most recently completed pass |
| ref_load | input | 1 | Store ref_value this cycle |
| ref_value | input | 11 | Reference value for the trailer comparison |
| match | output | 1 | Latest trailer equals the stored reference |

## Verification
A wrong CRC state never shows during the data phase, because data is forwarded unchanged. It first becomes visible in the trailer bits, starting one cycle after the end bit is forwarded, and on crc_full one cycle after the end bit is accepted. A wrong trailer counter shows as a trailer that is too short or too long, as a misplaced out_last, or as in_ready coming back early or late. The bench checks all of these against a software CRC on the cycle they are due. A CRC that is not cleared between passes shows only in the next pass, so the bench runs back-to-back passes, including passes that repeat the same data.

// File: rtl/rb_crc_pkg.sv
package rb_crc_pkg;

    typedef enum logic {
        PH_DATA  = 1'b0,
        PH_TRAIL = 1'b1
    } phase_e;

    typedef struct packed {
        logic bit_v;
        logic valid;
        logic last;
    } beat_t;

    localparam beat_t BEAT_IDLE = '{bit_v: 1'b0, valid: 1'b0, last: 1'b0};

endpackage

// File: rtl/rbc_crc_engine.sv
module rbc_crc_engine #(
    parameter int          CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             step_bit,
    input  logic             clear,
    input  rb_crc_pkg::phase_e phase,
    output logic [CRC_W-1:0] crc_next,
    output logic [CRC_W-1:0] crc_q
);
    import rb_crc_pkg::*;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic d);
        logic fb;
        fb = c[CRC_W-1] ^ d;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    endfunction

    assign crc_next = crc_step(crc_q, step_bit);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= '0;
        end else if (step_en) begin
            crc_q <= crc_next;
        end
    end

    // R6: the register is cleared throughout the trailer, ready for the next pass
    p_crc_zero_in_trailer_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TRAIL) |-> (crc_q == '0));

    // R5: the register does not step while input is refused
    p_no_step_in_trailer_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TRAIL) |-> !step_en);

endmodule

// File: rtl/rbc_trailer_seq.sv
module rbc_trailer_seq #(
    parameter int CRC_W   = 16,
    parameter int TRAIL_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [CRC_W-1:0]   start_crc,
    output rb_crc_pkg::phase_e phase,
    output rb_crc_pkg::beat_t  beat
);
    import rb_crc_pkg::*;

    localparam int CNT_W = (TRAIL_W > 1) ? $clog2(TRAIL_W) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(TRAIL_W - 1);

    phase_e             phase_q;
    logic [TRAIL_W-1:0] shift_q;
    logic [CNT_W-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_DATA;
            shift_q <= '0;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_DATA: begin
                    if (start) begin
                        phase_q <= PH_TRAIL;
                        shift_q <= start_crc[CRC_W-1 -: TRAIL_W];
                        cnt_q   <= '0;
                    end
                end
                PH_TRAIL: begin
                    shift_q <= {shift_q[TRAIL_W-2:0], 1'b0};
                    if (cnt_q == CNT_END) begin
                        phase_q <= PH_DATA;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_DATA;
            endcase
        end
    end

    assign phase = phase_q;

    always_comb begin
        beat = BEAT_IDLE;
        if (phase_q == PH_TRAIL) begin
            beat.bit_v = shift_q[TRAIL_W-1];
            beat.valid = 1'b1;
            beat.last  = (cnt_q == CNT_END);
        end
    end

    // R3: the trailer counter stays inside the 11-bit window
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_END);

    // R5: a new trailer cannot be started while one is running
    p_no_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TRAIL) |-> !start);

endmodule

// File: rtl/rbc_ref_compare.sv
module rbc_ref_compare #(
    parameter int CRC_W   = 16,
    parameter int TRAIL_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic [CRC_W-1:0]   capture_crc,
    input  logic               ref_load,
    input  logic [TRAIL_W-1:0] ref_value,
    output logic [CRC_W-1:0]   result,
    output logic               match
);
    logic [CRC_W-1:0]   result_q;
    logic [TRAIL_W-1:0] ref_q;
    logic               have_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            ref_q    <= '0;
            have_q   <= 1'b0;
        end else begin
            if (capture) begin
                result_q <= capture_crc;
                have_q   <= 1'b1;
            end
            if (ref_load) begin
                ref_q <= ref_value;
            end
        end
    end

    assign result = result_q;
    assign match  = have_q && (result_q[CRC_W-1 -: TRAIL_W] == ref_q);

    // R7: no match can be reported before any pass has completed
    p_match_needs_pass_r7: assert property (@(posedge clk) disable iff (rst)
        match |-> have_q);

    // R2: the held checksum only changes when a pass completes
    p_result_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(capture) |-> $stable(result_q));

endmodule

// File: rtl/rb_crc_appender.sv
module rb_crc_appender #(
    parameter int               CRC_W   = 16,
    parameter int               TRAIL_W = 11,
    parameter logic [CRC_W-1:0] POLY    = 16'h1021
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_bit,
    input  logic               in_valid,
    input  logic               in_last,
    output logic               in_ready,
    output logic               out_bit,
    output logic               out_valid,
    output logic               out_last,
    output logic [CRC_W-1:0]   crc_full,
    input  logic               ref_load,
    input  logic [TRAIL_W-1:0] ref_value,
    output logic               match
);
    import rb_crc_pkg::*;

    phase_e           phase;
    beat_t            trail_beat;
    beat_t            out_q;
    logic [CRC_W-1:0] crc_next;
    logic [CRC_W-1:0] crc_q;
    logic             in_fire;
    logic             pass_end;

    assign in_ready = (phase == PH_DATA);
    assign in_fire  = in_valid && in_ready;
    assign pass_end = in_fire && in_last;

    rbc_crc_engine #(.CRC_W(CRC_W), .POLY(POLY)) crc_i (
        .clk      (clk),
        .rst      (rst),
        .step_en  (in_fire),
        .step_bit (in_bit),
        .clear    (pass_end),
        .phase    (phase),
        .crc_next (crc_next),
        .crc_q    (crc_q)
    );

    rbc_trailer_seq #(.CRC_W(CRC_W), .TRAIL_W(TRAIL_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (pass_end),
        .start_crc (crc_next),
        .phase     (phase),
        .beat      (trail_beat)
    );

    rbc_ref_compare #(.CRC_W(CRC_W), .TRAIL_W(TRAIL_W)) cmp_i (
        .clk         (clk),
        .rst         (rst),
        .capture     (pass_end),
        .capture_crc (crc_next),
        .ref_load    (ref_load),
        .ref_value   (ref_value),
        .result      (crc_full),
        .match       (match)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= BEAT_IDLE;
        end else if (in_fire) begin
            out_q <= '{bit_v: in_bit, valid: 1'b1, last: 1'b0};
        end else begin
            out_q <= trail_beat;
        end
    end

    assign out_bit   = out_q.bit_v;
    assign out_valid = out_q.valid;
    assign out_last  = out_q.last;

    // R1: an accepted bit is forwarded on the next cycle
    p_pass_through_r1: assert property (@(posedge clk) disable iff (rst)
        in_fire |=> (out_valid && !out_last && out_bit == $past(in_bit)));

    // R4: the end flag only marks a valid bit
    p_last_is_valid_r4: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R5: input is refused on the cycle after an end bit is accepted
    p_stall_after_end_r5: assert property (@(posedge clk) disable iff (rst)
        pass_end |=> !in_ready);

    // R9: an idle data-phase cycle yields no output
    p_idle_gap_r9: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> !out_valid);

endmodule

// File: tb/rb_crc_appender_tb_top.sv
module rb_crc_appender_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_bit = 1'b0, in_valid = 1'b0, in_last = 1'b0;
    logic        in_ready, out_bit, out_valid, out_last, match;
    logic [15:0] crc_full;
    logic        ref_load = 1'b0;
    logic [10:0] ref_value = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Expected output stream: {bit, last}
    logic [1:0] expq[$];

    always #10 clk = ~clk;

    rb_crc_appender dut_i (
        .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .out_bit(out_bit), .out_valid(out_valid), .out_last(out_last),
        .crc_full(crc_full), .ref_load(ref_load), .ref_value(ref_value), .match(match)
    );

    function automatic logic [15:0] model_step(input logic [15:0] c, input logic d);
        logic fb;
        fb = c[15] ^ d;
        return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare every valid output bit with the expected stream
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R9 unexpected output bit", 1, 0);
                end else begin
                    logic [1:0] e;
                    e = expq.pop_front();
                    check(out_bit == e[1], "R1/R3 output bit", int'(out_bit), int'(e[1]));
                    check(out_last == e[0], "R4 output last", int'(out_last), int'(e[0]));
                end
            end else begin
                check(!out_last, "R4 last without valid", int'(out_last), 0);
            end
        end
    end

    // Run one pass; gap_pct gives the chance of an idle cycle between bits.
    task automatic run_pass(input logic bits[$], input int gap_pct, input bit stall_poke,
                            output logic [15:0] crc_out);
        logic [15:0] c;
        c = 16'h0000;
        for (int i = 0; i < bits.size(); i++) begin
            while (($urandom % 100) < gap_pct) begin
                @(negedge clk);
                in_valid = 1'b0;
                @(posedge clk);
            end
            @(negedge clk);
            check(in_ready, "R5 ready in data phase", int'(in_ready), 1);
            in_bit   = bits[i];
            in_valid = 1'b1;
            in_last  = (i == bits.size() - 1);
            @(posedge clk);
            #1;
            expq.push_back({bits[i], 1'b0});
            c = model_step(c, bits[i]);
        end
        for (int k = 15; k >= 5; k--) expq.push_back({c[k], (k == 5)});
        // R5: 11 stalled cycles, optionally with input offered and ignored
        for (int k = 0; k < 11; k++) begin
            @(negedge clk);
            if (k == 0) check(crc_full == c, "R2 crc_full after pass", int'(crc_full), int'(c));
            check(!in_ready, "R5 ready low in trailer", int'(in_ready), 0);
            in_valid = stall_poke;
            in_bit   = 1'($urandom);
            in_last  = stall_poke && 1'($urandom);
        end
        @(negedge clk);
        check(in_ready, "R5 ready back after trailer", int'(in_ready), 1);
        in_valid = 1'b0;
        in_last  = 1'b0;
        crc_out  = c;
    endtask

    initial begin
        logic bits[$];
        logic [15:0] c1, c2;
        void'($urandom(32'h1A2B3C4D));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        check(!out_valid && !out_last, "R8 outputs idle", int'({out_valid, out_last}), 0);
        check(in_ready, "R8 ready", int'(in_ready), 1);
        check(crc_full == 16'h0, "R8 crc_full", int'(crc_full), 0);
        check(!match, "R8 match", int'(match), 0);

        // R7: a loaded reference may not match before any pass
        ref_value = 11'h000; ref_load = 1'b1;
        @(negedge clk); ref_load = 1'b0;
        @(negedge clk);
        check(!match, "R7 no match before pass", int'(match), 0);

        // Directed: single-bit pass of 1 (R2 CRC of '1' is 0x1021)
        bits = '{1'b1};
        run_pass(bits, 0, 1'b0, c1);
        check(c1 == 16'h1021, "R2 model sanity", int'(c1), 16'h1021);

        // Directed: all zeros keeps CRC at zero (trailer all zero)
        bits = {};
        for (int i = 0; i < 20; i++) bits.push_back(1'b0);
        run_pass(bits, 0, 1'b0, c1);
        check(crc_full == 16'h0, "R2 zero data zero crc", int'(crc_full), 0);

        // Random passes with gaps (R9) and stall pokes (R5)
        for (int p = 0; p < 12; p++) begin
            bits = {};
            for (int i = 0; i < 8 + int'($urandom % 60); i++) bits.push_back(1'($urandom));
            run_pass(bits, 30, 1'(p % 2), c1);
        end

        // R6: identical passes give identical checksums; R7 match
        bits = {};
        for (int i = 0; i < 40; i++) bits.push_back(1'($urandom));
        run_pass(bits, 10, 1'b1, c1);
        ref_value = c1[15:5]; ref_load = 1'b1;
        @(negedge clk); ref_load = 1'b0;
        @(negedge clk);
        check(match, "R7 match after ref load", int'(match), 1);
        run_pass(bits, 20, 1'b1, c2);
        check(crc_full == c1, "R6 repeat pass same crc", int'(crc_full), int'(c1));
        check(match, "R7 match held on repeat", int'(match), 1);
        ref_value = c1[15:5] ^ 11'h001; ref_load = 1'b1;
        @(negedge clk); ref_load = 1'b0;
        @(negedge clk);
        check(!match, "R7 mismatch after ref change", int'(match), 0);

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R3 trailer fully sent", expq.size(), 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule